// File: doc/BRIEF.md
# Port Input Debounce Filter

This block cleans up the inputs of one general-purpose I/O port of eight pins before they reach the input register and the interrupt logic. Each raw pin is first brought into the clock domain through a short flop chain. A pin that has filtering switched on forwards a new level only after that level has held steady for a programmed number of millisecond ticks. A pin with filtering switched off forwards the synchronized level at once.

The whole port shares one stability count of up to 255 ms, and a count of zero turns filtering off for every pin. Each pin switches its own filtering on or off through a masked write. In that write the high half of the word selects which pins to touch and the low half carries their new enable values. A prescaler derives a one-cycle millisecond tick from a clock-frequency parameter. Rewriting the shared count does not restart filters that are already running. They compare their progress against the new value from the next tick on.

Top module: `port_debounce`

## Requirements
- R1: After reset the shared count reads 0, all enables read 0, and every output follows its synchronized input.
- R2: A count write loads the 8-bit value `cnt_wdata`, readable on `cnt_rd` from the next cycle. Without a write the count holds.
- R3: An enable write uses `en_wdata[15:8]` as a per-pin select mask and `en_wdata[7:0]` as the new enable values, where bit i maps to pin i. Pins whose mask bit is 0 keep their enable unchanged.
- R4: A pin whose enable is 0 forwards its raw input to `pins_out` with exactly two cycles of latency, the synchronizer depth.
- R5: With the shared count at 0, an enabled pin behaves like a disabled one and forwards its input after two cycles.
- R6: An enabled pin with count N > 0 forwards a new level no earlier than (N-1)*D cycles and no later than N*D+4 cycles after the raw change, where D is the tick period in cycles.
- R7: A level that reverts before the window of R6 has elapsed never reaches the output, because the filter's progress clears whenever input and output agree again.
- R8: Pins filter independently against the one shared count, and a disabled pin is not delayed by filtering on its neighbours.
- R9: A new count takes effect at the next tick without restarting filters in progress. A pin whose progress already reaches the new count flips on that tick.
- R10: The prescaler issues a single-cycle tick once every CLK_HZ/TICK_HZ cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| raw_pins | input | 8 | Asynchronous pin levels from the pads |
| cnt_wr | input | 1 | Write strobe for the shared count |
| cnt_wdata | input | 8 | New shared count in milliseconds |
| en_wr | input | 1 | Write strobe for the masked enable write |
| en_wdata | input | 16 | [15:8] pin select mask, [7:0] enable values |
| cnt_rd | output | 8 | Current shared count |
| en_rd | output | 8 | Current per-pin enables |
| pins_out | output | 8 | Filtered levels toward the input register and interrupt logic |

## Verification
Suppose a per-pin progress counter is wrong, for example not cleared on a bounce or cleared on a count rewrite. The pin's output then moves a whole tick period early or late, and the bench sees this within one tick window of the stimulus. A wrong enable bit from a faulty masked merge shows on `en_rd` in the next cycle. It also shows on `pins_out` as a pin that lags by ticks when it should follow after two cycles, or the reverse. A prescaler running at the wrong rate moves every filtered edge outside the bounds of R6. This shows at the smallest count, where the window is one tick.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

   // Per-pin decision taken each cycle by a filter lane
   typedef enum logic [1:0] {
      LANE_BYPASS = 2'd0,   // filtering off: follow the synchronized input
      LANE_HOLD   = 2'd1,   // input agrees with output: nothing pending
      LANE_COUNT  = 2'd2    // input disagrees: accumulate ticks
   } lane_mode_t;

   localparam int unsigned DEFAULT_TICK_HZ = 1000;

   function automatic int unsigned tick_divider(input int unsigned clk_hz,
                                                input int unsigned tick_hz);
      return clk_hz / tick_hz;
   endfunction

endpackage

// File: rtl/dbc_tick_gen.sv
module dbc_tick_gen #(
   parameter int unsigned CLK_HZ  = 125_000_000,
   parameter int unsigned TICK_HZ = dbc_pkg::DEFAULT_TICK_HZ
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned DIV   = dbc_pkg::tick_divider(CLK_HZ, TICK_HZ);
   localparam int unsigned DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

   initial begin
      if (DIV < 2) $fatal(1, "dbc_tick_gen: CLK_HZ must be at least twice TICK_HZ");
   end

   logic [DIV_W-1:0] div_q;
   logic             wrap;

   assign wrap = (div_q == DIV_W'(DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         tick  <= 1'b0;
      end else begin
         div_q <= wrap ? '0 : div_q + 1'b1;
         tick  <= wrap;
      end
   end

   // R10: tick is a single-cycle pulse
   p_tick_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
   // R10: prescaler never leaves its range
   p_presc_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      div_q <= DIV_W'(DIV - 1));

endmodule

// File: rtl/dbc_sync.sv
module dbc_sync #(
   parameter int unsigned PINS   = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] async_in,
   output logic [PINS-1:0] sync_out
);
   initial begin
      if (STAGES < 2) $fatal(1, "dbc_sync: at least two stages are required");
   end

   logic [PINS-1:0] stg_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[0] <= '0;
               else        stg_q[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[s] <= '0;
               else        stg_q[s] <= stg_q[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = stg_q[STAGES-1];

endmodule

// File: rtl/dbc_cfg_regs.sv
module dbc_cfg_regs #(
   parameter int unsigned PINS  = 8,
   parameter int unsigned CNT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_wr,
   input  logic [CNT_W-1:0]  cnt_wdata,
   input  logic              en_wr,
   input  logic [2*PINS-1:0] en_wdata,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [PINS-1:0]   en_q
);
   logic [PINS-1:0] sel_mask;
   logic [PINS-1:0] sel_vals;

   assign sel_mask = en_wdata[2*PINS-1:PINS];
   assign sel_vals = en_wdata[PINS-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         en_q  <= '0;
      end else begin
         if (cnt_wr) cnt_q <= cnt_wdata;
         if (en_wr)  en_q  <= (en_q & ~sel_mask) | (sel_vals & sel_mask);
      end
   end

   // R2: count holds when not written
   p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_wr |=> $stable(cnt_q));
   // R3: unselected enables keep their value across a masked write
   p_mask_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      en_wr |=> (((en_q ^ $past(en_q)) & ~$past(sel_mask)) == '0));
   // R3: enables hold when not written
   p_en_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !en_wr |=> $stable(en_q));

endmodule

// File: rtl/dbc_pin_filter.sv
module dbc_pin_filter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             bypass,
   input  logic             din,
   input  logic [CNT_W-1:0] limit,
   output logic             dout
);
   import dbc_pkg::*;

   lane_mode_t       mode;
   logic             filt_q;
   logic [CNT_W-1:0] prog_q;
   logic [CNT_W:0]   prog_next;
   logic             reached;

   always_comb begin
      if (bypass)             mode = LANE_BYPASS;
      else if (din == filt_q) mode = LANE_HOLD;
      else                    mode = LANE_COUNT;
   end

   assign prog_next = {1'b0, prog_q} + 1'b1;
   assign reached   = (prog_next >= {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_q <= 1'b0;
         prog_q <= '0;
      end else begin
         unique case (mode)
            LANE_BYPASS: begin
               filt_q <= din;
               prog_q <= '0;
            end
            LANE_HOLD: begin
               prog_q <= '0;
            end
            LANE_COUNT: begin
               if (tick) begin
                  if (reached) begin
                     filt_q <= din;
                     prog_q <= '0;
                  end else begin
                     prog_q <= prog_next[CNT_W-1:0];
                  end
               end
            end
            default: begin
               prog_q <= '0;
            end
         endcase
      end
   end

   assign dout = bypass ? din : filt_q;

   // R6: a filtering lane only changes its output on a tick
   p_flip_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == LANE_COUNT && !tick) |=> $stable(filt_q));
   // R7: an agreeing lane keeps its output
   p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == LANE_HOLD) |=> $stable(filt_q));
   // R7: a level that has reverted leaves no progress behind
   p_prog_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == LANE_HOLD) |=> (prog_q == '0));

endmodule

// File: rtl/port_debounce.sv
module port_debounce #(
   parameter int unsigned PINS        = 8,
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CLK_HZ      = 125_000_000,
   parameter int unsigned TICK_HZ     = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PINS-1:0]   raw_pins,
   input  logic              cnt_wr,
   input  logic [CNT_W-1:0]  cnt_wdata,
   input  logic              en_wr,
   input  logic [2*PINS-1:0] en_wdata,
   output logic [CNT_W-1:0]  cnt_rd,
   output logic [PINS-1:0]   en_rd,
   output logic [PINS-1:0]   pins_out
);
   localparam int unsigned WARM_W = $clog2(SYNC_STAGES + 1);

   initial begin
      if (PINS < 1)  $fatal(1, "port_debounce: PINS must be positive");
      if (CNT_W < 1) $fatal(1, "port_debounce: CNT_W must be positive");
   end

   logic              tick;
   logic [PINS-1:0]   sync_pins;
   logic [WARM_W-1:0] warm_q;
   logic              warm;
   logic              count_off;

   dbc_tick_gen #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) i_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   dbc_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (raw_pins),
      .sync_out (sync_pins)
   );

   dbc_cfg_regs #(.PINS(PINS), .CNT_W(CNT_W)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_wr    (cnt_wr),
      .cnt_wdata (cnt_wdata),
      .en_wr     (en_wr),
      .en_wdata  (en_wdata),
      .cnt_q     (cnt_rd),
      .en_q      (en_rd)
   );

   // Filters copy the input until the synchronizer holds real samples
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    warm_q <= '0;
      else if (!warm) warm_q <= warm_q + 1'b1;
   end
   assign warm      = (warm_q == WARM_W'(SYNC_STAGES));
   assign count_off = (cnt_rd == '0);

   genvar p;
   generate
      for (p = 0; p < PINS; p++) begin : g_lane
         dbc_pin_filter #(.CNT_W(CNT_W)) i_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .bypass (!en_rd[p] || count_off || !warm),
            .din    (sync_pins[p]),
            .limit  (cnt_rd),
            .dout   (pins_out[p])
         );
      end
   endgenerate

   // R4: a disabled pin carries the raw level two stages later
   p_bypass_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && $past(warm) && $past(warm, 2)) |->
         (((pins_out ^ $past(raw_pins, SYNC_STAGES)) & ~en_rd) == '0));
   // R1: the warm-up window ends and stays ended
   p_warm_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
      warm |=> warm);

endmodule

// File: tb/test_port_debounce.sv
module test_port_debounce;
   localparam int unsigned CLK_HZ = 8000;
   localparam int unsigned D      = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  raw_pins = 8'h00;
   logic        cnt_wr = 1'b0;
   logic [7:0]  cnt_wdata = 8'h00;
   logic        en_wr = 1'b0;
   logic [15:0] en_wdata = 16'h0000;
   logic [7:0]  cnt_rd, en_rd, pins_out;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   port_debounce #(.CLK_HZ(CLK_HZ), .TICK_HZ(1000)) i_port_debounce (
      .clk(clk), .rst_n(rst_n), .raw_pins(raw_pins),
      .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
      .en_wr(en_wr), .en_wdata(en_wdata),
      .cnt_rd(cnt_rd), .en_rd(en_rd), .pins_out(pins_out)
   );

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic set_count(input logic [7:0] v);
      cnt_wr = 1'b1; cnt_wdata = v;
      cyc(1);
      cnt_wr = 1'b0;
   endtask

   task automatic set_en(input logic [7:0] mask, input logic [7:0] vals);
      en_wr = 1'b1; en_wdata = {mask, vals};
      cyc(1);
      en_wr = 1'b0;
   endtask

   // Change raw level and check the filtered window for count n (R6)
   task automatic window(input int n, input logic [7:0] nv, input string req);
      logic [7:0] old;
      old = pins_out;
      raw_pins = nv;
      cyc((n - 1) * D);
      chk(req, pins_out, old);
      cyc(D + 4);
      chk(req, pins_out, nv);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(3);
      // R1: reset state and pass-through
      chk("R1 count", cnt_rd, 8'h00);
      chk("R1 enables", en_rd, 8'h00);
      raw_pins = 8'h5A;
      cyc(3);
      chk("R1 follow", pins_out, 8'h5A);
      raw_pins = 8'h00;
      cyc(3);

      // R2: count register
      set_count(8'hC3);
      chk("R2 write", cnt_rd, 8'hC3);
      cyc(2);
      chk("R2 hold", cnt_rd, 8'hC3);
      set_count(8'hFF);
      chk("R2 max", cnt_rd, 8'hFF);

      // R3: masked enable writes
      set_en(8'hFF, 8'h5A);
      chk("R3 full", en_rd, 8'h5A);
      set_en(8'h0F, 8'hF5);
      chk("R3 low nibble", en_rd, 8'h55);
      set_en(8'h00, 8'hFF);
      chk("R3 empty mask", en_rd, 8'h55);
      set_en(8'h81, 8'h80);
      chk("R3 ends", en_rd, 8'hD4);

      // R4: disabled pins follow with two cycles latency
      set_en(8'hFF, 8'h00);
      raw_pins = 8'hA5;
      cyc(1);
      chk("R4 one cycle", pins_out, 8'h00);
      cyc(1);
      chk("R4 two cycles", pins_out, 8'hA5);
      raw_pins = 8'h00;
      cyc(3);

      // R5: count 0 with all pins enabled is pass-through
      set_count(8'h00);
      set_en(8'hFF, 8'hFF);
      raw_pins = 8'h3C;
      cyc(1);
      chk("R5 one cycle", pins_out, 8'h00);
      cyc(1);
      chk("R5 two cycles", pins_out, 8'h3C);
      raw_pins = 8'h00;
      cyc(3);

      // R6/R10: sweep counts and pins, both edge directions
      for (int n = 1; n <= 5; n++) begin
         set_count(8'(n));
         for (int p = 0; p < 8; p++) begin
            window(n, 8'h01 << p, (n == 1) ? "R10 single tick" : "R6 rise");
            window(n, 8'h00, "R6 fall");
         end
      end

      // R7: short pulses never pass
      set_count(8'd4);
      raw_pins = 8'h10;
      cyc(D);
      raw_pins = 8'h00;
      for (int k = 0; k < 6; k++) begin
         cyc(D);
         chk("R7 pulse", pins_out, 8'h00);
      end
      for (int k = 0; k < 6; k++) begin
         raw_pins = (k % 2 == 0) ? 8'h10 : 8'h00;
         cyc(2 * D);
         chk("R7 chatter", pins_out, 8'h00);
      end
      raw_pins = 8'h00;
      cyc(6 * D);
      chk("R7 settle", pins_out, 8'h00);

      // R8: mixed enables, shared count 3
      set_count(8'd3);
      set_en(8'hFF, 8'h0F);
      raw_pins = 8'hFF;
      cyc(2);
      chk("R8 disabled fast", pins_out, 8'hF0);
      cyc(2 * D - 2);
      chk("R8 enabled wait", pins_out, 8'hF0);
      cyc(D + 4);
      chk("R8 all settled", pins_out, 8'hFF);
      raw_pins = 8'h00;
      cyc(3 * D + 4);
      chk("R8 back", pins_out, 8'h00);

      // R9: count rewrite without restart
      set_en(8'hFF, 8'hFF);
      set_count(8'd20);
      raw_pins = 8'h81;
      cyc(10 * D);
      chk("R9 before rewrite", pins_out, 8'h00);
      set_count(8'd5);
      cyc(D + 2);
      chk("R9 after rewrite", pins_out, 8'h81);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule